// File: doc/BRIEF.md
# Prefixed Instruction Combining Decoder

This stage sits at the front of instruction decode and turns a two-word prefixed instruction into a single decoded operation. Every cycle it may receive one fetched 32-bit word. Each word arrives with a valid flag, its byte address and a small pre-decoded instruction code. A word whose major opcode marks it as a prefix is held in the block, and nothing is emitted for it. The next valid word is taken as its suffix. The pair then leaves as one operation. That operation carries a converted code, the address of the prefix, the assembled 34-bit immediate, a program-counter-relative request, and flags for illegal form, alignment fault and prefixed origin.

Ordinary words pass straight through with one cycle of latency. The block never applies backpressure, so it accepts a word on every cycle. A flush input drops a held prefix together with any word presented in the same cycle. Downstream table lookup uses the emitted code unchanged. The legality and alignment flags travel beside that code, and the fault logic can act on them later.

Top module: `prefix_merge_decoder`

## Requirements
- R1: During reset and on the first cycle after it, out_valid is low and no prefix is held.
- R2: A valid word whose bits 31:26 are not 1, arriving with no prefix held, is emitted on the next cycle. It keeps its own code and address, and has out_prefixed, out_illegal, out_align_fault and out_pcrel at 0 and out_imm at 0.
- R3: A valid word whose bits 31:26 equal 1, arriving with no prefix held, is stored. out_valid is low on the next cycle.
- R4: The next valid word after a held prefix is its suffix, and is emitted on the next cycle with out_prefixed at 1 and out_code equal to the suffix code with bit 0 forced to 1. Cycles with in_valid low in between have no effect.
- R5: The combined address is the suffix address with bits 5:2 replaced by bits 5:2 of the prefix address.
- R6: out_align_fault is 1 on a combined output exactly when the prefix address modulo 64 is 60.
- R7: A combined output is legal only when all of the following hold. The subtype field (prefix bits 23:21) is 0. The suffix code is even. The suffix code lies in [MLS_LO, MLS_HI) when the type field (prefix bits 25:24) is 2'b10, or in [LS8_LO, LS8_HI) when it is 2'b00. Types 2'b01 and 2'b11 are always illegal.
- R8: out_imm equals prefix bits 17:0 placed above suffix bits 15:0. out_pcrel equals prefix bit 20.
- R9: flush suppresses the output on the next cycle and discards both a held prefix and the word presented with it. The next word is then treated as standalone.
- R10: A prefix that arrives while a prefix is held is consumed as the suffix. It is emitted with out_illegal at 1, and nothing stays held afterwards.
- R11: out_illegal never alters out_code. An illegal pair still carries the suffix code with bit 0 set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Discard held prefix and current word |
| in_valid | input | 1 | Fetched word is present |
| in_word | input | 32 | Fetched instruction word |
| in_addr | input | ADDR_W | Byte address of the word |
| in_code | input | CODE_W | Pre-decoded instruction code |
| out_valid | output | 1 | Decoded operation is present |
| out_code | output | CODE_W | Code for table lookup |
| out_addr | output | ADDR_W | Address of the operation |
| out_illegal | output | 1 | Prefix/suffix combination is not allowed |
| out_align_fault | output | 1 | Prefix sits at offset 60 of a 64-byte block |
| out_prefixed | output | 1 | Operation came from a prefix pair |
| out_pcrel | output | 1 | Program-counter-relative addressing requested |
| out_imm | output | 34 | Combined immediate |

## Verification
Two checks can fire on the same combined output: the alignment check on the held prefix's address, and the legality check on the type, subtype and suffix code. The bench drives prefixes at offset 60 with both legal and illegal suffixes, including a second prefix used as the suffix. It expects both flags to be set in the same output cycle with the code unchanged. A flush presented in the same cycle as a would-be suffix is also checked, and must win over pairing.

// File: rtl/pfx_pkg.sv
package pfx_pkg;
  localparam logic [5:0] PFX_MAJOR = 6'd1;

  typedef enum logic [1:0] {
    PT_LS8  = 2'b00,
    PT_RSV1 = 2'b01,
    PT_MLS  = 2'b10,
    PT_RSV3 = 2'b11
  } pfx_type_e;

  localparam int IMM_HI_W = 18;
  localparam int IMM_LO_W = 16;
  localparam int IMM_W    = IMM_HI_W + IMM_LO_W;

  function automatic logic is_prefix_word(input logic [31:0] w);
    return w[31:26] == PFX_MAJOR;
  endfunction
endpackage

// File: rtl/pfx_hold.sv
module pfx_hold #(
  parameter int LOW_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             capture,
  input  logic             clear,
  input  logic [31:0]      word_in,
  input  logic [LOW_W-1:0] alow_in,
  output logic             held_valid,
  output logic [31:0]      held_word,
  output logic [LOW_W-1:0] held_alow
);
  logic             valid_d;
  logic [31:0]      word_d;
  logic [LOW_W-1:0] alow_d;

  always_comb begin
    valid_d = held_valid;
    word_d  = held_word;
    alow_d  = held_alow;
    if (clear) begin
      valid_d = 1'b0;
    end else if (capture) begin
      valid_d = 1'b1;
      word_d  = word_in;
      alow_d  = alow_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_valid <= 1'b0;
      held_word  <= '0;
      held_alow  <= '0;
    end else begin
      held_valid <= valid_d;
      if (capture && !clear) begin
        held_word <= word_d;
        held_alow <= alow_d;
      end
    end
  end
endmodule

// File: rtl/pfx_check.sv
module pfx_check
  import pfx_pkg::*;
#(
  parameter int CODE_W = 9,
  parameter int MLS_LO = 64,
  parameter int MLS_HI = 96,
  parameter int LS8_LO = 96,
  parameter int LS8_HI = 112
) (
  input  logic [31:0]       pfx_word,
  input  logic [3:0]        pfx_alow,
  input  logic [15:0]       sfx_low,
  input  logic [CODE_W-1:0] sfx_code,
  input  logic              sfx_is_pfx,
  output logic              illegal,
  output logic              align_fault,
  output logic              pcrel,
  output logic [IMM_W-1:0]  imm
);
  pfx_type_e ptype;
  logic      in_range;

  always_comb begin
    ptype = pfx_type_e'(pfx_word[25:24]);
    unique case (ptype)
      PT_MLS:  in_range = (int'(sfx_code) >= MLS_LO) && (int'(sfx_code) < MLS_HI);
      PT_LS8:  in_range = (int'(sfx_code) >= LS8_LO) && (int'(sfx_code) < LS8_HI);
      default: in_range = 1'b0;
    endcase
    illegal     = sfx_is_pfx || !in_range || sfx_code[0] || (pfx_word[23:21] != 3'd0);
    align_fault = (pfx_alow == 4'hF);
    pcrel       = pfx_word[20];
    imm         = {pfx_word[IMM_HI_W-1:0], sfx_low};
  end
endmodule

// File: rtl/prefix_merge_decoder.sv
module prefix_merge_decoder
  import pfx_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CODE_W = 9,
  parameter int MLS_LO = 64,
  parameter int MLS_HI = 96,
  parameter int LS8_LO = 96,
  parameter int LS8_HI = 112
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              in_valid,
  input  logic [31:0]       in_word,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [CODE_W-1:0] in_code,
  output logic              out_valid,
  output logic [CODE_W-1:0] out_code,
  output logic [ADDR_W-1:0] out_addr,
  output logic              out_illegal,
  output logic              out_align_fault,
  output logic              out_prefixed,
  output logic              out_pcrel,
  output logic [33:0]       out_imm
);
  localparam int LOW_W = 4;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync;
  logic       rst_q_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q_n = rst_sync[1];

  logic              held_valid;
  logic [31:0]       held_word;
  logic [LOW_W-1:0]  held_alow;
  logic              accept, word_pfx, capture, pair, single, clear, emit;
  logic              chk_illegal, chk_align, chk_pcrel;
  logic [IMM_W-1:0]  chk_imm;

  assign accept   = in_valid && !flush;
  assign word_pfx = is_prefix_word(in_word);
  assign capture  = accept && word_pfx && !held_valid;
  assign pair     = accept && held_valid;
  assign single   = accept && !word_pfx && !held_valid;
  assign clear    = flush || pair;
  assign emit     = pair || single;

  pfx_hold #(.LOW_W(LOW_W)) hold_u (
    .clk        (clk),
    .rst_n      (rst_q_n),
    .capture    (capture),
    .clear      (clear),
    .word_in    (in_word),
    .alow_in    (in_addr[5:2]),
    .held_valid (held_valid),
    .held_word  (held_word),
    .held_alow  (held_alow)
  );

  pfx_check #(
    .CODE_W(CODE_W), .MLS_LO(MLS_LO), .MLS_HI(MLS_HI),
    .LS8_LO(LS8_LO), .LS8_HI(LS8_HI)
  ) check_u (
    .pfx_word    (held_word),
    .pfx_alow    (held_alow),
    .sfx_low     (in_word[15:0]),
    .sfx_code    (in_code),
    .sfx_is_pfx  (word_pfx),
    .illegal     (chk_illegal),
    .align_fault (chk_align),
    .pcrel       (chk_pcrel),
    .imm         (chk_imm)
  );

  logic              valid_d, illegal_d, align_d, prefixed_d, pcrel_d;
  logic [CODE_W-1:0] code_d;
  logic [ADDR_W-1:0] addr_d;
  logic [33:0]       imm_d;

  always_comb begin
    valid_d    = emit;
    code_d     = in_code;
    addr_d     = in_addr;
    illegal_d  = 1'b0;
    align_d    = 1'b0;
    prefixed_d = 1'b0;
    pcrel_d    = 1'b0;
    imm_d      = '0;
    if (pair) begin
      code_d     = in_code | CODE_W'(1);
      addr_d     = {in_addr[ADDR_W-1:6], held_alow, in_addr[1:0]};
      illegal_d  = chk_illegal;
      align_d    = chk_align;
      prefixed_d = 1'b1;
      pcrel_d    = chk_pcrel;
      imm_d      = chk_imm;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      out_valid       <= 1'b0;
      out_code        <= '0;
      out_addr        <= '0;
      out_illegal     <= 1'b0;
      out_align_fault <= 1'b0;
      out_prefixed    <= 1'b0;
      out_pcrel       <= 1'b0;
      out_imm         <= '0;
    end else begin
      out_valid <= valid_d;
      if (emit) begin
        out_code        <= code_d;
        out_addr        <= addr_d;
        out_illegal     <= illegal_d;
        out_align_fault <= align_d;
        out_prefixed    <= prefixed_d;
        out_pcrel       <= pcrel_d;
        out_imm         <= imm_d;
      end
    end
  end
endmodule

// File: rtl/prefix_merge_decoder_chk.sv
module prefix_merge_decoder_chk #(
  parameter int ADDR_W = 32,
  parameter int CODE_W = 9
) (
  input logic              clk,
  input logic              rst_q_n,
  input logic              flush,
  input logic              in_valid,
  input logic [31:0]       in_word,
  input logic [ADDR_W-1:0] in_addr,
  input logic              held_valid,
  input logic              out_valid,
  input logic [CODE_W-1:0] out_code,
  input logic [ADDR_W-1:0] out_addr,
  input logic              out_illegal,
  input logic              out_align_fault,
  input logic              out_prefixed,
  input logic              out_pcrel,
  input logic [33:0]       out_imm
);
  logic pfx_in;
  assign pfx_in = in_valid && !flush && (in_word[31:26] == 6'd1);

  assert_prefix_silent_R3: assert property (@(posedge clk) disable iff (!rst_q_n)
    pfx_in && !held_valid |=> !out_valid);

  assert_flush_quiet_R9: assert property (@(posedge clk) disable iff (!rst_q_n)
    flush |=> !out_valid && !held_valid);

  assert_code_lsb_R4: assert property (@(posedge clk) disable iff (!rst_q_n)
    out_valid && out_prefixed |-> out_code[0]);

  assert_upper_addr_R5: assert property (@(posedge clk) disable iff (!rst_q_n)
    out_valid && out_prefixed |-> out_addr[ADDR_W-1:6] == $past(in_addr[ADDR_W-1:6]));

  assert_align_offset_R6: assert property (@(posedge clk) disable iff (!rst_q_n)
    out_valid && out_align_fault |-> out_prefixed && out_addr[5:2] == 4'hF);

  assert_plain_clean_R2: assert property (@(posedge clk) disable iff (!rst_q_n)
    out_valid && !out_prefixed |-> !out_illegal && !out_align_fault && !out_pcrel && out_imm == 34'd0);

  assert_double_prefix_R10: assert property (@(posedge clk) disable iff (!rst_q_n)
    pfx_in && held_valid |=> out_valid && out_illegal && !held_valid);
endmodule

bind prefix_merge_decoder prefix_merge_decoder_chk #(.ADDR_W(ADDR_W), .CODE_W(CODE_W)) chk_u (
  .clk             (clk),
  .rst_q_n         (rst_q_n),
  .flush           (flush),
  .in_valid        (in_valid),
  .in_word         (in_word),
  .in_addr         (in_addr),
  .held_valid      (held_valid),
  .out_valid       (out_valid),
  .out_code        (out_code),
  .out_addr        (out_addr),
  .out_illegal     (out_illegal),
  .out_align_fault (out_align_fault),
  .out_prefixed    (out_prefixed),
  .out_pcrel       (out_pcrel),
  .out_imm         (out_imm)
);

// File: tb/prefix_merge_decoder_tb_top.sv
module prefix_merge_decoder_tb_top;
  localparam int AW = 32;
  localparam int CW = 9;

  logic          clk = 1'b0;
  logic          rst_n, flush, in_valid;
  logic [31:0]   in_word;
  logic [AW-1:0] in_addr;
  logic [CW-1:0] in_code;
  logic          out_valid, out_illegal, out_align_fault, out_prefixed, out_pcrel;
  logic [CW-1:0] out_code;
  logic [AW-1:0] out_addr;
  logic [33:0]   out_imm;

  always #5 clk = ~clk;

  prefix_merge_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .flush(flush), .in_valid(in_valid),
    .in_word(in_word), .in_addr(in_addr), .in_code(in_code),
    .out_valid(out_valid), .out_code(out_code), .out_addr(out_addr),
    .out_illegal(out_illegal), .out_align_fault(out_align_fault),
    .out_prefixed(out_prefixed), .out_pcrel(out_pcrel), .out_imm(out_imm)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference state
  bit          m_held;
  logic [31:0] m_word;
  logic [AW-1:0] m_addr;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit ref_legal(logic [31:0] p, logic [CW-1:0] c, bit s_pfx);
    bit ok;
    ok = (p[23:21] == 3'd0) && !c[0] && !s_pfx;
    if (p[25:24] == 2'b10)      ok = ok && (c >= 64) && (c < 96);
    else if (p[25:24] == 2'b00) ok = ok && (c >= 96) && (c < 112);
    else                        ok = 0;
    return ok;
  endfunction

  // one cycle: drive at negedge, predict, compare at next negedge
  task automatic step(bit v, logic [31:0] w, logic [AW-1:0] a, logic [CW-1:0] c, bit fl);
    bit e_v, e_ill, e_al, e_pf, e_pc, s_pfx;
    logic [CW-1:0] e_code;
    logic [AW-1:0] e_addr;
    logic [33:0] e_imm;
    in_valid = v; in_word = w; in_addr = a; in_code = c; flush = fl;
    s_pfx = (w[31:26] == 6'd1);
    e_v = 0; e_ill = 0; e_al = 0; e_pf = 0; e_pc = 0; e_code = c; e_addr = a; e_imm = '0;
    if (fl) begin
      m_held = 0;                                   // R9
    end else if (v && m_held) begin                 // R4 pairing
      e_v = 1; e_pf = 1; e_code = c | 9'd1;
      e_addr = {a[AW-1:6], m_addr[5:2], a[1:0]};    // R5
      e_al = (m_addr[5:0] == 6'd60);                // R6
      e_ill = !ref_legal(m_word, c, s_pfx);         // R7 R10
      e_pc = m_word[20];                            // R8
      e_imm = {m_word[17:0], w[15:0]};
      m_held = 0;
    end else if (v && s_pfx) begin                  // R3
      m_held = 1; m_word = w; m_addr = a;
    end else if (v) begin                           // R2
      e_v = 1;
    end
    @(posedge clk);
    @(negedge clk);
    chk("R1/R3/R9 valid", 64'(out_valid), 64'(e_v));
    if (e_v) begin
      chk(e_pf ? "R4 R11 code" : "R2 code", 64'(out_code), 64'(e_code));
      chk(e_pf ? "R5 addr" : "R2 addr", 64'(out_addr), 64'(e_addr));
      chk("R4 prefixed", 64'(out_prefixed), 64'(e_pf));
      chk("R6 align", 64'(out_align_fault), 64'(e_al));
      chk("R7 R10 illegal", 64'(out_illegal), 64'(e_ill));
      chk("R8 pcrel", 64'(out_pcrel), 64'(e_pc));
      chk("R8 imm", 64'(out_imm), 64'(e_imm));
    end
  endtask

  function automatic logic [31:0] mk_pfx(logic [1:0] t, logic [2:0] st, bit r, logic [17:0] d);
    return {6'd1, t, st, r, 2'b00, d};
  endfunction

  function automatic logic [31:0] mk_plain(logic [31:0] r);
    logic [31:0] x;
    x = r;
    if (x[31:26] == 6'd1) x[31:26] = 6'd14;
    return x;
  endfunction

  initial begin
    rst_n = 1'b0; flush = 0; in_valid = 0; in_word = '0; in_addr = '0; in_code = '0;
    m_held = 0; m_word = '0; m_addr = '0;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk("R1 reset valid", 64'(out_valid), 64'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 after reset", 64'(out_valid), 64'd0);

    // R2 standalone word
    step(1, 32'h7C00_1234, 32'h0000_1000, 9'd40, 0);
    // R3/R4/R8 legal MLS, pcrel, gaps between prefix and suffix
    step(1, mk_pfx(2'b10, 3'd0, 1, 18'h2ABCD), 32'h0000_2010, 9'd0, 0);
    step(0, 32'h0, 32'h0, 9'd0, 0);
    step(0, 32'h0, 32'h0, 9'd0, 0);
    step(1, 32'h3800_BEEF, 32'h0000_2014, 9'd70, 0);
    // R6 + R10 in the same output: prefix at offset 60, then another prefix
    step(1, mk_pfx(2'b00, 3'd0, 0, 18'h00011), 32'h0000_303C, 9'd0, 0);
    step(1, mk_pfx(2'b10, 3'd0, 0, 18'h00022), 32'h0000_3040, 9'd100, 0);
    step(1, 32'h8000_0001, 32'h0000_3044, 9'd5, 0); // standalone afterwards
    // R6 + R7 legal 8LS at offset 60
    step(1, mk_pfx(2'b00, 3'd0, 1, 18'h3FFFF), 32'h0000_40BC, 9'd0, 0);
    step(1, 32'h9000_FFFF, 32'h0000_40C0, 9'd98, 0);
    // R7 reserved type, nonzero subtype, odd code; R11 code intact
    step(1, mk_pfx(2'b01, 3'd0, 0, 18'h1), 32'h0000_5000, 9'd0, 0);
    step(1, 32'h9000_0001, 32'h0000_5004, 9'd64, 0);
    step(1, mk_pfx(2'b10, 3'd2, 0, 18'h1), 32'h0000_5008, 9'd0, 0);
    step(1, 32'h9000_0002, 32'h0000_500C, 9'd66, 0);
    step(1, mk_pfx(2'b10, 3'd0, 0, 18'h1), 32'h0000_5010, 9'd0, 0);
    step(1, 32'h9000_0003, 32'h0000_5014, 9'd67, 0);
    // R9 flush with held prefix, flush same cycle as suffix
    step(1, mk_pfx(2'b10, 3'd0, 0, 18'h5), 32'h0000_6000, 9'd0, 0);
    step(1, 32'h9000_0004, 32'h0000_6004, 9'd70, 1);
    step(1, 32'h9000_0005, 32'h0000_6008, 9'd72, 0);
    step(1, mk_pfx(2'b10, 3'd0, 0, 18'h6), 32'h0000_603C, 9'd0, 0);
    step(0, 32'h0, 32'h0, 9'd0, 1);
    step(1, 32'h9000_0006, 32'h0000_6040, 9'd74, 0);

    // constrained random
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] w, a;
      logic [CW-1:0] c;
      bit v, fl;
      v  = ($urandom % 10) < 8;
      fl = ($urandom % 20) == 0;
      a  = $urandom & 32'hFFFF_FFFC;
      if (($urandom % 4) == 0) a[5:0] = 6'd60;
      c  = 9'($urandom % 128);
      if (($urandom % 10) < 3)
        w = mk_pfx(2'($urandom), (($urandom % 4) == 0) ? 3'($urandom) : 3'd0,
                   1'($urandom), 18'($urandom));
      else
        w = mk_plain($urandom);
      step(v, w, a, c, fl);
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule